// File: doc/BRIEF.md
# Single-Wire Register Port Slave

This block lets a host reach a set of device registers over one shared open-drain line. The host opens every transaction with a break, a long low pulse followed by a high recovery interval. It then sends a command byte: the top bit selects write (1) or read (0), and the low seven bits name a register. A write command is followed by one data byte from the host, which the block passes to the device core as a single write strobe. A read command makes the block fetch the byte from the core and shift it back over the same line.

Every bit travels in a return-to-one cell. The cell opens with a falling edge, the level in the middle of the cell carries the data, and the line goes high again before the cell ends. Bytes go least-significant bit first in both directions. The block never drives the line high. It only asserts an open-drain enable that pulls the line low, and all timing is counted in clock ticks set by parameters.

Top module: `swire_port`

## Requirements
- R1: A break is the line held low for at least BREAK_TICKS clock ticks. A shorter low pulse never starts a transaction, so bits sent after it cause no register access.
- R2: After a break the line must stay high for RECOVER_TICKS ticks before a command bit is accepted. A falling edge inside that window cancels the break, and the bits that follow cause no access.
- R3: Each received bit is the level of the synchronised line (VALID_TICKS+HOLD_TICKS)/2 ticks after the cell's falling edge. Bits arrive least-significant first, so the first bit received is bit 0 of the byte.
- R4: A command with bit 7 = 1 and address bits 6:0 in {03h, 04h, 05h, 0Ah} is followed by one data byte. That byte produces exactly one single-cycle reg_wr_o pulse, with reg_addr_o set to the address and reg_wdata_o set to the byte.
- R5: A write command to any other address (except 39h, see R6) produces no reg_wr_o pulse.
- R6: A write to address 39h produces a reg_wr_o pulse only when the data byte is 80h. Any other value is dropped.
- R7: A command with bit 7 = 0 and an address in {01h, 02h, 03h, 04h, 05h, 06h, 17h} produces one reg_rd_o pulse. The block then sends reg_rdata_i least-significant bit first, in cells of TX_CELL_TICKS ticks. In each cell it pulls the line low for TX_START_TICKS ticks for a 1 bit and for TX_DATA_TICKS ticks for a 0 bit. It waits to start until RX_CELL_TICKS have passed since the last command cell began and the line is high.
- R8: A read command to any other address produces no reg_rd_o pulse, and the block sends 00h.
- R9: A break at any point, including during a data byte or during transmission, aborts the transfer with no access, releases the line, and begins a new recovery.
- R10: line_oe_o is low out of reset and is asserted only while a read byte is being transmitted.
- R11: After a completed write or read the block waits for a new break. Bits sent without one cause no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Level of the shared line |
| line_oe_o | output | 1 | Pull-down enable for the line (1 = drive low) |
| reg_addr_o | output | 7 | Register address of the current access |
| reg_wr_o | output | 1 | Single-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rd_o | output | 1 | Single-cycle read strobe |
| reg_rdata_i | input | 8 | Read data from the core, valid while reg_rd_o is high |

## Verification
Three situations are hard to reach from the ports: a break that lands in the middle of a byte, a break that lands while the slave is itself pulling the line, and a recovery window cut short by an early edge. The directed stimulus builds each one with a host model that shapes the line low times tick by tick. To start a break during a read, it waits for the slave's own first falling edge and then holds the line down over the slave's cells. Each aborted sequence is followed by a clean write, and the count of write strobes shows whether the abort leaked an access.

// File: rtl/swire_pkg.sv
package swire_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BRK,
        ST_RECOV,
        ST_RX_CMD,
        ST_RX_DATA,
        ST_TURN,
        ST_RD,
        ST_TX
    } port_state_e;

    localparam logic [6:0] ADDR_RESET = 7'h39;
    localparam logic [7:0] RESET_KEY  = 8'h80;

    function automatic logic rd_allowed(input logic [6:0] a);
        case (a)
            7'h01, 7'h02, 7'h03, 7'h04, 7'h05, 7'h06, 7'h17: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic wr_allowed(input logic [6:0] a, input logic [7:0] d);
        case (a)
            7'h03, 7'h04, 7'h05, 7'h0A: return 1'b1;
            ADDR_RESET:                 return (d == RESET_KEY);
            default:                    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/swire_sync.sv
module swire_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o,
    output logic fall_o
);
    logic [STAGES:0] sh_q;
    logic [STAGES:0] sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign line_o = sh_q[STAGES-1];
    assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

endmodule

// File: rtl/swire_break_det.sv
module swire_break_det #(
    parameter int unsigned BREAK_TICKS = 3000,
    localparam int unsigned BW = $clog2(BREAK_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic brk_o
);
    localparam logic [BW-1:0] LIMIT = BW'(BREAK_TICKS);
    localparam logic [BW-1:0] FIRE  = BW'(BREAK_TICKS - 1);

    logic [BW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (line_i)              cnt_d = '0;
        else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
        else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign brk_o = !line_i && (cnt_q == FIRE);

    // R1: one break pulse per low period
    a_r1_single_break: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |=> !brk_o);
    // R1: a break only while the line is low and after it was low before
    a_r1_low_before: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o && !$past(brk_o) && $past(rst_n) |-> !$past(line_i) || (BREAK_TICKS == 1));

endmodule

// File: rtl/swire_tx_cell.sv
module swire_tx_cell #(
    parameter int unsigned START_TICKS = 500,
    parameter int unsigned DATA_TICKS  = 1500,
    parameter int unsigned CELL_TICKS  = 3000,
    localparam int unsigned TW = $clog2(CELL_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_i,
    input  logic bit_i,
    input  logic abort_i,
    output logic drive_o,
    output logic done_o
);
    localparam logic [TW-1:0] LAST   = TW'(CELL_TICKS - 1);
    localparam logic [TW-1:0] T_START = TW'(START_TICKS);
    localparam logic [TW-1:0] T_DATA  = TW'(DATA_TICKS);

    typedef struct packed {
        logic          busy;
        logic          bitv;
        logic [TW-1:0] cnt;
    } cell_t;

    cell_t q, d;

    always_comb begin
        d = q;
        done_o = q.busy && (q.cnt == LAST);
        if (q.busy) d.cnt = q.cnt + 1'b1;
        if (done_o) d.busy = 1'b0;
        if (go_i && (!q.busy || done_o)) begin
            d.busy = 1'b1;
            d.bitv = bit_i;
            d.cnt  = '0;
        end
        if (abort_i) begin
            d.busy = 1'b0;
            d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign drive_o = q.busy && ((q.cnt < T_START) || ((q.cnt < T_DATA) && !q.bitv));

    // R7: the pull-down is never released before the start width
    a_r7_start_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_o) && q.busy |-> q.cnt >= T_START);
    // R7: every cell begins with a drive-low tick
    a_r7_cell_opens_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> drive_o);

endmodule

// File: rtl/swire_port.sv
module swire_port
    import swire_pkg::*;
#(
    parameter int unsigned BREAK_TICKS    = 3000,
    parameter int unsigned RECOVER_TICKS  = 1000,
    parameter int unsigned VALID_TICKS    = 750,
    parameter int unsigned HOLD_TICKS     = 1500,
    parameter int unsigned RX_CELL_TICKS  = 3000,
    parameter int unsigned TX_START_TICKS = 500,
    parameter int unsigned TX_DATA_TICKS  = 1500,
    parameter int unsigned TX_CELL_TICKS  = 3000,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    output logic       line_oe_o,
    output logic [6:0] reg_addr_o,
    output logic       reg_wr_o,
    output logic [7:0] reg_wdata_o,
    output logic       reg_rd_o,
    input  logic [7:0] reg_rdata_i
);
    localparam int unsigned SAMPLE_TICKS = (VALID_TICKS + HOLD_TICKS) / 2;
    localparam int unsigned MAXT = (RX_CELL_TICKS > RECOVER_TICKS) ? RX_CELL_TICKS : RECOVER_TICKS;
    localparam int unsigned CW = $clog2(MAXT + 1);
    localparam logic [CW-1:0] TMR_MAX   = '1;
    localparam logic [CW-1:0] SAMPLE_AT = CW'(SAMPLE_TICKS - 1);
    localparam logic [CW-1:0] REC_AT    = CW'(RECOVER_TICKS - 1);
    localparam logic [CW-1:0] CELL_AT   = CW'(RX_CELL_TICKS - 1);

    typedef struct packed {
        port_state_e   st;
        logic [CW-1:0] tmr;
        logic          in_cell;
        logic [2:0]    bitn;
        logic [7:0]    sh;
        logic [6:0]    addr;
        logic [7:0]    wdata;
        logic          wr;
        logic          rd;
    } port_t;

    port_t q, d;

    logic line_s, fall_s, brk;
    logic tx_go, tx_bit, tx_done, tx_drive;
    logic [7:0] sampled;

    swire_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .line_o(line_s), .fall_o(fall_s)
    );

    swire_break_det #(.BREAK_TICKS(BREAK_TICKS)) u_brk (
        .clk(clk), .rst_n(rst_n), .line_i(line_s), .brk_o(brk)
    );

    swire_tx_cell #(
        .START_TICKS(TX_START_TICKS), .DATA_TICKS(TX_DATA_TICKS), .CELL_TICKS(TX_CELL_TICKS)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .go_i(tx_go), .bit_i(tx_bit), .abort_i(brk),
        .drive_o(tx_drive), .done_o(tx_done)
    );

    always_comb begin
        d       = q;
        d.wr    = 1'b0;
        d.rd    = 1'b0;
        tx_go   = 1'b0;
        tx_bit  = 1'b0;
        sampled = {line_s, q.sh[7:1]};

        if (q.in_cell && q.tmr != TMR_MAX) d.tmr = q.tmr + 1'b1;

        case (q.st)
            ST_IDLE: begin
                d.in_cell = 1'b0;
            end
            ST_BRK: begin
                if (line_s) begin
                    d.st  = ST_RECOV;
                    d.tmr = '0;
                end
            end
            ST_RECOV: begin
                if (!line_s) begin
                    d.st = ST_IDLE;
                end else if (q.tmr == REC_AT) begin
                    d.st      = ST_RX_CMD;
                    d.in_cell = 1'b0;
                    d.bitn    = '0;
                end else begin
                    d.tmr = q.tmr + 1'b1;
                end
            end
            ST_RX_CMD, ST_RX_DATA: begin
                if (fall_s) begin
                    d.in_cell = 1'b1;
                    d.tmr     = '0;
                end else if (q.in_cell && q.tmr == SAMPLE_AT) begin
                    d.sh   = sampled;
                    d.bitn = q.bitn + 3'd1;
                    if (q.bitn == 3'd7) begin
                        if (q.st == ST_RX_CMD) begin
                            d.addr = sampled[6:0];
                            d.st   = sampled[7] ? ST_RX_DATA : ST_TURN;
                        end else begin
                            d.wr      = wr_allowed(q.addr, sampled);
                            d.wdata   = sampled;
                            d.st      = ST_IDLE;
                            d.in_cell = 1'b0;
                        end
                    end
                end
            end
            ST_TURN: begin
                if (q.tmr >= CELL_AT && line_s) begin
                    d.st      = ST_RD;
                    d.rd      = rd_allowed(q.addr);
                    d.in_cell = 1'b0;
                end
            end
            ST_RD: begin
                d.sh   = q.rd ? reg_rdata_i : 8'h00;
                tx_go  = 1'b1;
                tx_bit = d.sh[0];
                d.bitn = '0;
                d.st   = ST_TX;
            end
            ST_TX: begin
                if (tx_done) begin
                    if (q.bitn == 3'd7) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.bitn = q.bitn + 3'd1;
                        d.sh   = q.sh >> 1;
                        tx_go  = 1'b1;
                        tx_bit = q.sh[1];
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (brk) begin
            d.st      = ST_BRK;
            d.in_cell = 1'b0;
            d.bitn    = '0;
            d.wr      = 1'b0;
            d.rd      = 1'b0;
            tx_go     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign line_oe_o   = tx_drive;
    assign reg_addr_o  = q.addr;
    assign reg_wdata_o = q.wdata;
    assign reg_wr_o    = q.wr;
    assign reg_rd_o    = q.rd;

    // R10: the line is pulled only while a read byte goes out
    a_r10_drive_in_tx: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe_o |-> q.st == ST_TX);
    // R4: never a read and a write strobe together
    a_r4_one_access: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr_o, reg_rd_o}));
    // R4: write strobe lasts one cycle
    a_r4_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);
    // R6: the reset register only ever sees its key
    a_r6_reset_key: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o && reg_addr_o == ADDR_RESET |-> reg_wdata_o == RESET_KEY);
    // R9: a break always lands the port in the break state
    a_r9_break_abort: assert property (@(posedge clk) disable iff (!rst_n)
        brk |=> q.st == ST_BRK && !line_oe_o);
    // R7: a read strobe is followed by transmission
    a_r7_rd_then_tx: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o && !brk |=> q.st == ST_TX);

endmodule

// File: tb/swire_port_test.sv
module swire_port_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_low = 1'b0;
    logic line_w;
    logic line_oe;
    logic [6:0] addr;
    logic wr, rd;
    logic [7:0] wdata, rdata;

    int checks = 0;
    int fails  = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [6:0] last_wa;
    logic [7:0] last_wd;

    always #2 clk = ~clk;

    assign line_w = !(host_low || line_oe);
    assign rdata  = {1'b0, addr} ^ 8'hA5;

    swire_port #(
        .BREAK_TICKS(60), .RECOVER_TICKS(20), .VALID_TICKS(15), .HOLD_TICKS(30),
        .RX_CELL_TICKS(60), .TX_START_TICKS(10), .TX_DATA_TICKS(30), .TX_CELL_TICKS(60)
    ) uut (
        .clk(clk), .rst_n(rst_n), .line_i(line_w), .line_oe_o(line_oe),
        .reg_addr_o(addr), .reg_wr_o(wr), .reg_wdata_o(wdata),
        .reg_rd_o(rd), .reg_rdata_i(rdata)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (wr) begin
                wr_cnt  <= wr_cnt + 1;
                last_wa <= addr;
                last_wd <= wdata;
            end
            if (rd) rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_break();
        host_low = 1'b1; tick(80);
        host_low = 1'b0; tick(30);
    endtask

    task automatic host_bit(input logic b);
        host_low = 1'b1; tick(5);
        host_low = !b;   tick(35);
        host_low = 1'b0; tick(20);
    endtask

    task automatic host_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) host_bit(v[i]);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] v);
        host_break();
        host_byte({1'b1, a});
        host_byte(v);
        tick(5);
    endtask

    // receive one byte from the slave, checking each cell's low width (R7)
    task automatic get_byte(output logic [7:0] v, output logic ok);
        int w;
        int lim;
        ok = 1'b1;
        v  = 8'h00;
        for (int i = 0; i < 8; i++) begin
            lim = 0;
            while (line_w && lim < 400) begin tick(1); lim++; end
            if (lim >= 400) begin ok = 1'b0; return; end
            w = 0;
            while (!line_w && w < 100) begin tick(1); w++; end
            v[i] = (w < 20);
            check((w >= 9 && w <= 11) || (w >= 29 && w <= 31), "R7 cell low width", w, v[i] ? 10 : 30);
        end
    endtask

    task automatic do_read(input logic [6:0] a, output logic [7:0] v, output logic ok);
        host_break();
        host_byte({1'b0, a});
        get_byte(v, ok);
        tick(40);
    endtask

    task automatic t_reset();
        check(line_oe == 1'b0, "R10 oe after reset", line_oe, 0);
        check(wr == 1'b0 && rd == 1'b0, "R10 strobes after reset", {wr, rd}, 0);
    endtask

    task automatic t_writes();
        int c;
        c = wr_cnt;
        do_write(7'h04, 8'h3C);
        check(wr_cnt == c + 1, "R4 one write strobe", wr_cnt - c, 1);
        check(last_wa == 7'h04 && last_wd == 8'h3C, "R4 write addr/data", {last_wa, last_wd}, {7'h04, 8'h3C});
        do_write(7'h05, 8'h01);
        check(last_wa == 7'h05 && last_wd == 8'h01, "R3 lsb first 01", last_wd, 8'h01);
        do_write(7'h0A, 8'h80);
        check(last_wa == 7'h0A && last_wd == 8'h80, "R3 lsb first 80", last_wd, 8'h80);
        check(wr_cnt == c + 3, "R4 write count", wr_cnt - c, 3);
        check(line_oe == 1'b0, "R10 no drive on writes", line_oe, 0);
    endtask

    task automatic t_bad_writes();
        int c;
        c = wr_cnt;
        do_write(7'h01, 8'h55);
        do_write(7'h22, 8'hAA);
        check(wr_cnt == c, "R5 invalid addr ignored", wr_cnt - c, 0);
    endtask

    task automatic t_reset_reg();
        int c;
        c = wr_cnt;
        do_write(7'h39, 8'h40);
        check(wr_cnt == c, "R6 wrong key ignored", wr_cnt - c, 0);
        do_write(7'h39, 8'h80);
        check(wr_cnt == c + 1 && last_wa == 7'h39 && last_wd == 8'h80, "R6 key accepted", wr_cnt - c, 1);
    endtask

    task automatic t_reads();
        logic [7:0] v;
        logic ok;
        int c;
        c = rd_cnt;
        do_read(7'h03, v, ok);
        check(ok && v == (8'h03 ^ 8'hA5), "R7 read 03", v, 8'h03 ^ 8'hA5);
        check(rd_cnt == c + 1, "R7 one read strobe", rd_cnt - c, 1);
        do_read(7'h17, v, ok);
        check(ok && v == (8'h17 ^ 8'hA5), "R7 read 17", v, 8'h17 ^ 8'hA5);
        c = rd_cnt;
        do_read(7'h39, v, ok);
        check(ok && v == 8'h00, "R8 unreadable sends 00", v, 0);
        check(rd_cnt == c, "R8 no read strobe", rd_cnt - c, 0);
        check(line_oe == 1'b0, "R10 released after read", line_oe, 0);
    endtask

    task automatic t_short_low();
        int c;
        tick(100);
        c = wr_cnt;
        host_low = 1'b1; tick(40);
        host_low = 1'b0; tick(30);
        host_byte({1'b1, 7'h04});
        host_byte(8'h11);
        tick(5);
        check(wr_cnt == c, "R1 short low no break", wr_cnt - c, 0);
    endtask

    task automatic t_recovery_cut();
        int c;
        c = wr_cnt;
        host_low = 1'b1; tick(80);
        host_low = 1'b0; tick(8);
        host_byte({1'b1, 7'h04});
        host_byte(8'h22);
        tick(5);
        check(wr_cnt == c, "R2 early edge cancels", wr_cnt - c, 0);
    endtask

    task automatic t_abort();
        int c;
        int lim;
        c = wr_cnt;
        host_break();
        host_byte({1'b1, 7'h04});
        for (int i = 0; i < 4; i++) host_bit(1'b0);
        do_write(7'h05, 8'h77);
        check(wr_cnt == c + 1 && last_wa == 7'h05 && last_wd == 8'h77, "R9 abort mid data", wr_cnt - c, 1);
        host_break();
        host_byte({1'b0, 7'h03});
        lim = 0;
        while (!line_oe && lim < 400) begin tick(1); lim++; end
        host_break();
        check(line_oe == 1'b0, "R9 break during tx releases", line_oe, 0);
        c = wr_cnt;
        do_write(7'h04, 8'h5A);
        check(wr_cnt == c + 1 && last_wd == 8'h5A, "R9 clean write after abort", last_wd, 8'h5A);
    endtask

    task automatic t_no_break_follow();
        int c;
        c = wr_cnt;
        host_byte({1'b1, 7'h04});
        host_byte(8'h99);
        tick(5);
        check(wr_cnt == c, "R11 no access without break", wr_cnt - c, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tick(5);
        t_reset();
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_writes();
        t_bad_writes();
        t_reset_reg();
        t_reads();
        t_short_low();
        t_recovery_cut();
        t_abort();
        t_no_break_follow();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule